// File: doc/BRIEF.md
# Four-Way Age-Counter LRU Tracker

This block holds the replacement order for a small set-associative cache: eight sets of four ways, each way with a 2-bit age. Age 3 marks the way touched most recently and age 0 marks the way touched longest ago, so the four ages of a set always form an ordering of 0 to 3. Tags and data are kept elsewhere. The cache controller tells the block which set and way it touched, and the block moves that way to the youngest position.

On each access, the accessed way takes age 3. Only the ways that were younger than it move one step older. Ways that were already older keep their age, so their relative order is preserved. The ages of the set on the select input and the number of the way holding age 0 are always on the outputs. That way is the one to replace on a miss.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, every set holds age w for way w (way0=0, way1=1, way2=2, way3=3).
- R2: On a clock edge with `touch` high, the way on `way_sel` in the set on `set_sel` takes age 3.
- R3: On that edge, each other way of that set whose age was greater than the accessed way's old age is decremented by one.
- R4: On that edge, each other way of that set whose age was less than the accessed way's old age keeps its age.
- R5: On an edge with `touch` low, no age in any set changes.
- R6: An update changes only the set on `set_sel`; the other seven sets keep their ages.
- R7: `victim` is combinational and gives the number of the way whose age is 0 in the set currently on `set_sel`. Before the edge it reflects the ages from before an update in that cycle.
- R8: The four ages of every set always form a permutation of 0 to 3.
- R9: Touching the way that already has age 3 leaves all four ages of the set unchanged.
- R10: `ages_out` shows the selected set's ages with way w in bits [2w+1:2w].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_sel | input | 3 | Set being read and, with `touch`, updated |
| way_sel | input | 2 | Way accessed in the selected set |
| touch | input | 1 | Update strobe; applies the access on the next rising edge |
| ages_out | output | 8 | Ages of the selected set, way w in bits [2w+1:2w] |
| victim | output | 2 | Way of the selected set whose age is 0 |

## Verification
The victim report and the age update can fall in the same cycle. The controller reads the replacement way of a set while it strobes an access to that set, often to the victim way itself. The bench drives `touch` with a set and way just after a falling edge and samples `ages_out` and `victim` before the rising edge. There it expects the old ordering and the old victim. After the edge it expects the reordered ages and a new victim, all computed by a behavioural model. Touches of the youngest way, of the victim way and of other sets are mixed in, both directed and at random.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

   // Index width for a count of items, never less than one bit.
   function automatic int unsigned idx_width(input int unsigned count);
      return (count <= 2) ? 1 : $clog2(count);
   endfunction

   // True when count is a power of two and at least two.
   function automatic bit is_pow2(input int unsigned count);
      return (count >= 2) && ((count & (count - 1)) == 0);
   endfunction

endpackage

// File: rtl/lru_age_next.sv
// Next-age computation for one set: the hit way goes to the top age and
// the ways above its old age step down by one.
module lru_age_next #(
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned AGE_W    = 2
) (
   input  logic [NUM_WAYS-1:0][AGE_W-1:0] cur_ages,
   input  logic [AGE_W-1:0]               hit_way,
   output logic [NUM_WAYS-1:0][AGE_W-1:0] nxt_ages
);
   localparam logic [AGE_W-1:0] TOP_AGE = {AGE_W{1'b1}};

   logic [AGE_W-1:0] hit_age;
   assign hit_age = cur_ages[hit_way];

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      logic is_hit;
      logic younger;
      assign is_hit  = (hit_way == AGE_W'(w));
      assign younger = (cur_ages[w] > hit_age);
      always_comb begin
         if (is_hit)
            nxt_ages[w] = TOP_AGE;
         else if (younger)
            nxt_ages[w] = cur_ages[w] - AGE_W'(1);
         else
            nxt_ages[w] = cur_ages[w];
      end
   end

endmodule

// File: rtl/lru_victim_find.sv
// Picks the way whose age is zero.
module lru_victim_find #(
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned AGE_W    = 2
) (
   input  logic [NUM_WAYS-1:0][AGE_W-1:0] ages,
   output logic [AGE_W-1:0]               victim_way
);
   logic [NUM_WAYS-1:0] is_oldest;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_zero
      assign is_oldest[w] = (ages[w] == '0);
   end

   always_comb begin
      victim_way = '0;
      for (int w = NUM_WAYS - 1; w >= 0; w--) begin
         if (is_oldest[w]) victim_way = AGE_W'(w);
      end
   end

endmodule

// File: rtl/lru_age_store.sv
// Age registers for all sets; reset loads age w into way w.
module lru_age_store #(
   parameter int unsigned NUM_SETS = 8,
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned AGE_W    = 2,
   parameter int unsigned SET_W    = 3
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       wr_en,
   input  logic [SET_W-1:0]                           wr_set,
   input  logic [NUM_WAYS-1:0][AGE_W-1:0]             wr_ages,
   output logic [NUM_SETS-1:0][NUM_WAYS-1:0][AGE_W-1:0] ages_arr
);
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic sel_here;
      assign sel_here = wr_en && (wr_set == SET_W'(s));
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ages_arr[s][w] <= AGE_W'(w);
            else if (sel_here)
               ages_arr[s][w] <= wr_ages[w];
         end
      end
   end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
   parameter int unsigned NUM_SETS = 8,
   parameter int unsigned NUM_WAYS = 4,
   localparam int unsigned SET_W   = lru_age_pkg::idx_width(NUM_SETS),
   localparam int unsigned WAY_W   = lru_age_pkg::idx_width(NUM_WAYS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SET_W-1:0]          set_sel,
   input  logic [WAY_W-1:0]          way_sel,
   input  logic                      touch,
   output logic [NUM_WAYS*WAY_W-1:0] ages_out,
   output logic [WAY_W-1:0]          victim
);
   if (!lru_age_pkg::is_pow2(NUM_WAYS)) begin : g_bad_ways
      $fatal(1, "NUM_WAYS must be a power of two, at least 2");
   end
   if (!lru_age_pkg::is_pow2(NUM_SETS)) begin : g_bad_sets
      $fatal(1, "NUM_SETS must be a power of two, at least 2");
   end

   logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] ages_arr;
   logic [NUM_WAYS-1:0][WAY_W-1:0]               cur_set;
   logic [NUM_WAYS-1:0][WAY_W-1:0]               nxt_set;
   logic [NUM_SETS*NUM_WAYS*WAY_W-1:0]           all_ages_flat;

   assign cur_set       = ages_arr[set_sel];
   assign ages_out      = cur_set;
   assign all_ages_flat = ages_arr;

   lru_age_next #(.NUM_WAYS(NUM_WAYS), .AGE_W(WAY_W)) u_next (
      .cur_ages (cur_set),
      .hit_way  (way_sel),
      .nxt_ages (nxt_set)
   );

   lru_age_store #(
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS),
      .AGE_W    (WAY_W),
      .SET_W    (SET_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (touch),
      .wr_set   (set_sel),
      .wr_ages  (nxt_set),
      .ages_arr (ages_arr)
   );

   lru_victim_find #(.NUM_WAYS(NUM_WAYS), .AGE_W(WAY_W)) u_victim (
      .ages       (cur_set),
      .victim_way (victim)
   );

endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk #(
   parameter int unsigned NUM_SETS = 8,
   parameter int unsigned NUM_WAYS = 4,
   parameter int unsigned SET_W    = 3,
   parameter int unsigned WAY_W    = 2
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [SET_W-1:0]                   set_sel,
   input logic [WAY_W-1:0]                   way_sel,
   input logic                               touch,
   input logic [NUM_WAYS*WAY_W-1:0]          ages_out,
   input logic [WAY_W-1:0]                   victim,
   input logic [NUM_SETS*NUM_WAYS*WAY_W-1:0] all_ages
);
   localparam int unsigned SETB = NUM_WAYS * WAY_W;
   localparam logic [WAY_W-1:0] TOP = {WAY_W{1'b1}};

   logic                               armed;
   logic [NUM_SETS*NUM_WAYS*WAY_W-1:0] prev_all;
   logic [SET_W-1:0]                   prev_set;
   logic [WAY_W-1:0]                   prev_way;
   logic                               prev_touch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed      <= 1'b0;
         prev_all   <= '0;
         prev_set   <= '0;
         prev_way   <= '0;
         prev_touch <= 1'b0;
      end else begin
         armed      <= 1'b1;
         prev_all   <= all_ages;
         prev_set   <= set_sel;
         prev_way   <= way_sel;
         prev_touch <= touch;
      end
   end

   logic youngest_ok, dec_ok, hold_ok, others_ok, perm_ok, victim_ok;

   always_comb begin
      logic [WAY_W-1:0]    hit_old, old_a, new_a;
      logic [NUM_WAYS-1:0] seen;
      int unsigned         base;
      base        = 32'(prev_set) * SETB;
      hit_old     = prev_all[base + 32'(prev_way) * WAY_W +: WAY_W];
      youngest_ok = (all_ages[base + 32'(prev_way) * WAY_W +: WAY_W] == TOP);
      dec_ok      = 1'b1;
      hold_ok     = 1'b1;
      for (int w = 0; w < NUM_WAYS; w++) begin
         old_a = prev_all[base + 32'(w) * WAY_W +: WAY_W];
         new_a = all_ages[base + 32'(w) * WAY_W +: WAY_W];
         if (WAY_W'(w) != prev_way) begin
            if (old_a > hit_old && new_a != old_a - WAY_W'(1)) dec_ok  = 1'b0;
            if (old_a < hit_old && new_a != old_a)             hold_ok = 1'b0;
         end
      end
      others_ok = 1'b1;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (SET_W'(s) != prev_set &&
             all_ages[32'(s) * SETB +: SETB] != prev_all[32'(s) * SETB +: SETB])
            others_ok = 1'b0;
      end
      seen = '0;
      for (int w = 0; w < NUM_WAYS; w++)
         seen[ages_out[32'(w) * WAY_W +: WAY_W]] = 1'b1;
      perm_ok   = (seen == {NUM_WAYS{1'b1}});
      victim_ok = (ages_out[32'(victim) * WAY_W +: WAY_W] == '0);
   end

   p_youngest_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_touch) |-> youngest_ok);
   p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_touch) |-> dec_ok);
   p_hold_older_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_touch) |-> hold_ok);
   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !prev_touch) |-> (all_ages == prev_all));
   p_other_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && prev_touch) |-> others_ok);
   p_victim_r7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> victim_ok);
   p_permutation_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> perm_ok);

endmodule

bind lru_age_tracker lru_age_chk #(
   .NUM_SETS (NUM_SETS),
   .NUM_WAYS (NUM_WAYS),
   .SET_W    (SET_W),
   .WAY_W    (WAY_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .set_sel  (set_sel),
   .way_sel  (way_sel),
   .touch    (touch),
   .ages_out (ages_out),
   .victim   (victim),
   .all_ages (all_ages_flat)
);

// File: tb/tb_lru_age_tracker.sv
`timescale 1ns/1ps
module tb_lru_age_tracker;
   localparam int NS = 8;
   localparam int NW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] set_sel = '0;
   logic [1:0] way_sel = '0;
   logic       touch = 1'b0;
   logic [7:0] ages_out;
   logic [1:0] victim;

   int mdl [NS][NW];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   lru_age_tracker dut (
      .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .way_sel(way_sel),
      .touch(touch), .ages_out(ages_out), .victim(victim)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // Compare the outputs of set s against the model (R10 packing, R7, R8).
   task automatic observe(input int s, input string tag);
      int vic;
      int seen;
      vic  = -1;
      seen = 0;
      for (int w = 0; w < NW; w++) begin
         chk(tag, int'(ages_out[2*w +: 2]), mdl[s][w]);
         if (mdl[s][w] == 0) vic = w;
         seen |= (1 << int'(ages_out[2*w +: 2]));
      end
      chk("R7 victim", int'(victim), vic);
      chk("R8 permutation", seen, 15);
   endtask

   task automatic model_touch(input int s, input int w);
      int h;
      h = mdl[s][w];
      for (int v = 0; v < NW; v++) begin
         if (v == w) mdl[s][v] = 3;
         else if (mdl[s][v] > h) mdl[s][v] = mdl[s][v] - 1;
      end
   endtask

   // One cycle: drive after the falling edge, sample before the rising edge.
   task automatic step(input int s, input int w, input bit t, input string tag);
      @(negedge clk);
      set_sel = 3'(s);
      way_sel = 2'(w);
      touch   = t;
      #1;
      observe(s, tag);
      @(posedge clk);
      if (t) model_touch(s, w);
   endtask

   initial begin
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) mdl[s][w] = w;   // R1 reset ordering
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R10: every set shows way w at age w
      for (int s = 0; s < NS; s++) step(s, 0, 0, "R1 R10 reset ages");

      // R2 R3 R4: worked ordering on set 5
      step(5, 1, 1, "R1 before access");
      step(5, 0, 1, "R2 R3 R4 after way1");
      chk("R3 literal way2", int'(ages_out[5:4]), 1);
      chk("R4 literal way0", int'(ages_out[1:0]), 0);
      step(5, 0, 0, "R2 R3 after way0");
      chk("R2 literal way0", int'(ages_out[1:0]), 3);
      chk("R3 literal way3", int'(ages_out[7:6]), 1);

      // R9: touch the youngest way
      step(5, 0, 1, "R9 before");
      step(5, 2, 0, "R9 unchanged");

      // R5: strobe low, varying way
      for (int w = 0; w < NW; w++) step(5, w, 0, "R5 idle");

      // R6: other sets untouched by set 5 activity
      for (int s = 0; s < NS; s++) step(s, 3, 0, "R6 other sets");

      // R7: touch the victim way; pre-edge victim is the old one
      step(3, 0, 1, "R7 touch victim");
      step(3, 1, 1, "R7 new victim");
      step(3, 1, 0, "R7 after");

      // Random mix: R2 R3 R4 R6 R8
      for (int i = 0; i < 3000; i++)
         step(int'($urandom_range(NS - 1)), int'($urandom_range(NW - 1)),
              bit'($urandom_range(3) != 0), "R2 R3 R4 R6 random");
      for (int s = 0; s < NS; s++) step(s, 0, 0, "R6 R8 final scan");

      finish_run();
   end
endmodule